// File: doc/BRIEF.md
# SAR Serial Result Sequencer

This block is the digital control for a 14-bit successive-approximation converter whose result is shifted out while the conversion is still running. An asynchronous rising edge on the convert-start input is brought into the converter clock domain. The block then puts the track/hold into hold and runs one comparator decision per clock through a trial-bit register that drives the internal DAC word. Each result bit goes onto a framed serial line in the same cycle it is decided.

The serial word has 16 bits. It opens with two zero bits and then carries the 14-bit two's-complement result, most significant bit first. An active-low frame strobe covers the word. The serial clock is a copy of the converter clock with an output enable. In gated mode the enable is high only while a frame is open. In continuous mode it is always high. Counted from the first clock edge that samples the start input high, a conversion ends on the 19th rising edge. A start edge that misses the capture aperture of one edge is taken on the next edge, which gives 20 edges.

Top module: `sar_serial_seq`

## Requirements
- R1: The frame strobe falls and the hold output rises on the third rising clock edge, counting the first edge that samples start_i high as edge one. This holds for any phase of the start edge within the clock period.
- R2: The frame strobe stays low and hold stays high for exactly 16 clock periods. Both return on the 19th rising edge.
- R3: On the edge that opens the frame, trial_o is loaded with only its top bit set (0x2000). After the last decision, trial_o holds the offset-binary result and keeps it until the next frame.
- R4: In clock period k of the frame (k = 0..15), sdata_o carries word bit 15-k, where the word is two zero bits followed by the 14-bit result. The data changes on a rising edge and is sampled on the following falling edge.
- R5: A comparator value of 1 means the input is at or above the trial level, and the tried bit is kept. The serial result is two's complement: the offset-binary result with its top bit inverted. All ones from the comparator give 1FFF hex, and all zeros give 2000 hex.
- R6: In gated mode (free_run_i = 0), sclk_oe_o is high only while the frame strobe is low. sclk_o follows clk while enabled and is low otherwise.
- R7: In continuous mode (free_run_i = 1), sclk_oe_o is always high, so sclk_o follows clk even between frames.
- R8: A start edge that arrives while a frame is open is ignored. The frame keeps its length, and no new frame follows it.
- R9: Outside a frame, sdata_o is low and trial_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Asynchronous convert-start, acts on its rising edge |
| cmp_i | input | 1 | Comparator decision, 1 = input at or above trial level |
| free_run_i | input | 1 | 1 = serial clock runs continuously, 0 = gated to the frame |
| trial_o | output | 14 | Successive-approximation trial word (offset binary) to the DAC |
| hold_o | output | 1 | 1 = track/hold in hold |
| frame_n_o | output | 1 | Active-low frame strobe |
| sclk_o | output | 1 | Serial clock, a copy of clk while enabled |
| sclk_oe_o | output | 1 | Output enable of the serial clock pad |
| sdata_o | output | 1 | Serial data |

## Verification
A bench comparator model converts a swept input level: every 97th code plus the codes around both full scales and around mid-scale. This separates errors in bit order, sign inversion and keep-or-drop of trial bits. Start edges are placed just after, midway through and just before a clock edge, to confirm that the frame opens a fixed number of edges after capture. Conversions alternate between gated and continuous serial clock modes, so that enable behaviour between frames is told apart. One run re-arms the start input in the middle of a frame to show that the frame neither restarts nor repeats.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;
    // default geometry of the converter word and the serial frame
    parameter int unsigned SAR_RES_W   = 14;
    parameter int unsigned SAR_LEAD_W  = 2;
    parameter int unsigned SAR_SYNC_N  = 2;

    // counter width able to hold 0..n
    function automatic int unsigned sar_w_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/sar_start_sync.sv
`timescale 1ns/1ps
module sar_start_sync #(
    parameter int unsigned STAGES = sar_seq_pkg::SAR_SYNC_N
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-1:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/sar_frame_ctl.sv
`timescale 1ns/1ps
module sar_frame_ctl #(
    parameter int unsigned RES_W  = sar_seq_pkg::SAR_RES_W,
    parameter int unsigned LEAD_W = sar_seq_pkg::SAR_LEAD_W,
    parameter int unsigned IDX_W  = sar_seq_pkg::sar_w_for(RES_W - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    output logic             active_o,
    output logic             launch_o,
    output logic             decide_o,
    output logic             done_o,
    output logic [IDX_W-1:0] bit_idx_o
);
    localparam int unsigned LAST_SLOT = LEAD_W + RES_W - 1;
    localparam int          FIRST_DEC = int'(LEAD_W) - 1;
    localparam int          LAST_DEC  = int'(LEAD_W + RES_W) - 2;
    localparam int unsigned CNT_W     = sar_seq_pkg::sar_w_for(LAST_SLOT);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t st_d, st_q;

    always_comb begin
        launch_o  = rise_i & ~st_q.active;
        done_o    = st_q.active && (int'(st_q.cnt) == int'(LAST_SLOT));
        decide_o  = st_q.active && (int'(st_q.cnt) >= FIRST_DEC) &&
                    (int'(st_q.cnt) <= LAST_DEC);
        bit_idx_o = IDX_W'(LAST_DEC - int'(st_q.cnt));

        st_d = st_q;
        if (launch_o) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (done_o) begin
            st_d.active = 1'b0;
            st_d.cnt    = '0;
        end else if (st_q.active) begin
            st_d.cnt    = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = st_q.active;
endmodule

// File: rtl/sar_trial_reg.sv
`timescale 1ns/1ps
module sar_trial_reg #(
    parameter int unsigned RES_W = sar_seq_pkg::SAR_RES_W,
    parameter int unsigned IDX_W = sar_seq_pkg::sar_w_for(RES_W - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_i,
    input  logic             decide_i,
    input  logic [IDX_W-1:0] bit_idx_i,
    input  logic             cmp_i,
    output logic [RES_W-1:0] trial_o
);
    logic [RES_W-1:0] trial_d, trial_q;

    always_comb begin
        trial_d = trial_q;
        if (launch_i) begin
            trial_d            = '0;
            trial_d[RES_W-1]   = 1'b1;
        end else if (decide_i) begin
            // settle the tried bit, then try the next lower one
            trial_d[bit_idx_i] = cmp_i;
            if (bit_idx_i != '0)
                trial_d[IDX_W'(bit_idx_i - 1'b1)] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trial_q <= '0;
        else        trial_q <= trial_d;
    end

    assign trial_o = trial_q;
endmodule

// File: rtl/sar_serial_seq.sv
`timescale 1ns/1ps
module sar_serial_seq #(
    parameter int unsigned RES_W  = sar_seq_pkg::SAR_RES_W,
    parameter int unsigned LEAD_W = sar_seq_pkg::SAR_LEAD_W,
    parameter int unsigned SYNC_N = sar_seq_pkg::SAR_SYNC_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_i,
    input  logic             free_run_i,
    output logic [RES_W-1:0] trial_o,
    output logic             hold_o,
    output logic             frame_n_o,
    output logic             sclk_o,
    output logic             sclk_oe_o,
    output logic             sdata_o
);
    localparam int unsigned IDX_W = sar_seq_pkg::sar_w_for(RES_W - 1);

    typedef struct packed {
        logic sdata;
    } ser_t;

    logic             rise, active, launch, decide, done;
    logic [IDX_W-1:0] bit_idx;
    ser_t             ser_d, ser_q;

    sar_start_sync #(.STAGES(SYNC_N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (start_i),
        .rise_o  (rise)
    );

    sar_frame_ctl #(.RES_W(RES_W), .LEAD_W(LEAD_W), .IDX_W(IDX_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (rise),
        .active_o  (active),
        .launch_o  (launch),
        .decide_o  (decide),
        .done_o    (done),
        .bit_idx_o (bit_idx)
    );

    sar_trial_reg #(.RES_W(RES_W), .IDX_W(IDX_W)) u_trial (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch_i  (launch),
        .decide_i  (decide),
        .bit_idx_i (bit_idx),
        .cmp_i     (cmp_i),
        .trial_o   (trial_o)
    );

    always_comb begin
        ser_d = ser_q;
        if (launch || done) begin
            ser_d.sdata = 1'b0;
        end else if (decide) begin
            // top bit goes out inverted: offset binary -> two's complement
            ser_d.sdata = (int'(bit_idx) == int'(RES_W) - 1) ? ~cmp_i : cmp_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ser_q <= '0;
        else        ser_q <= ser_d;
    end

    assign sdata_o   = ser_q.sdata;
    assign hold_o    = active;
    assign frame_n_o = ~active;
    assign sclk_oe_o = free_run_i | active;
    assign sclk_o    = clk & sclk_oe_o;
endmodule

// File: rtl/sar_serial_seq_chk.sv
`timescale 1ns/1ps
module sar_serial_seq_chk #(
    parameter int unsigned RES_W  = sar_seq_pkg::SAR_RES_W,
    parameter int unsigned LEAD_W = sar_seq_pkg::SAR_LEAD_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             free_run_i,
    input logic [RES_W-1:0] trial_o,
    input logic             hold_o,
    input logic             frame_n_o,
    input logic             sclk_oe_o,
    input logic             sdata_o
);
    localparam int unsigned WORD_W = LEAD_W + RES_W;
    localparam int unsigned RUN_W  = sar_seq_pkg::sar_w_for(WORD_W + 1);

    // periods the frame strobe has been low so far, saturating
    logic [RUN_W-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             run_q <= '0;
        else if (frame_n_o)                     run_q <= '0;
        else if (int'(run_q) <= int'(WORD_W))   run_q <= run_q + 1'b1;
    end

    // R2: frame closes only after exactly WORD_W periods
    a_r2_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_n_o) |-> (int'($past(run_q)) == int'(WORD_W) - 1));

    // R8: an open frame is not cut short by anything
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n_o && int'(run_q) < int'(WORD_W) - 1) |=> !frame_n_o);

    // R2: hold follows the frame
    a_r2_hold_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_n_o) |-> hold_o);

    // R4: leading slots are zero
    a_r4_lead_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n_o && int'(run_q) < int'(LEAD_W)) |-> !sdata_o);

    // R3: trial starts at mid-scale when the frame opens
    a_r3_trial_mid: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_n_o) |-> (trial_o == {1'b1, {(RES_W-1){1'b0}}}));

    // R6: gated mode keeps the serial clock off between frames
    a_r6_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!free_run_i && frame_n_o) |-> !sclk_oe_o);

    // R7: continuous mode keeps the clock enabled
    a_r7_free_on: assert property (@(posedge clk) disable iff (!rst_n)
        free_run_i |-> sclk_oe_o);

    // R9: idle line is low, trial word frozen
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_n_o && $past(frame_n_o)) |-> (!sdata_o && $stable(trial_o)));
endmodule

bind sar_serial_seq sar_serial_seq_chk #(.RES_W(RES_W), .LEAD_W(LEAD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .free_run_i (free_run_i),
    .trial_o    (trial_o),
    .hold_o     (hold_o),
    .frame_n_o  (frame_n_o),
    .sclk_oe_o  (sclk_oe_o),
    .sdata_o    (sdata_o)
);

// File: tb/sar_serial_seq_tb.sv
`timescale 1ns/1ps
module sar_serial_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        free_run = 1'b0;
    int          level = 0;
    logic [13:0] trial;
    logic        cmp, hold, frame_n, sclk, sclk_oe, sdata;
    int          total = 0;
    int          bad = 0;

    always #2.5 clk = ~clk;

    // comparator model: input at or above trial level keeps the bit (R5)
    assign cmp = (level >= int'(trial));

    sar_serial_seq dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .cmp_i      (cmp),
        .free_run_i (free_run),
        .trial_o    (trial),
        .hold_o     (hold),
        .frame_n_o  (frame_n),
        .sclk_o     (sclk),
        .sclk_oe_o  (sclk_oe),
        .sdata_o    (sdata)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_conv(input int x, input logic fr, input realtime ph, input bit poke);
        logic [15:0] word;
        word = {2'b00, 14'(x) ^ 14'h2000};
        free_run = fr;
        level = x;
        @(posedge clk); #ph; start = 1'b1;
        for (int e = 1; e <= 2; e++) begin
            @(posedge clk); @(negedge clk);
            check("R1 frame still idle", int'(frame_n), 1);
        end
        for (int k = 0; k < 16; k++) begin
            @(posedge clk); #1;
            if (k == 8) check("R6 sclk high in frame", int'(sclk), 1);
            @(negedge clk);
            check("R4 serial bit", int'(sdata), int'(word[15-k]));
            check("R2 frame low", int'(frame_n), 0);
            if (k == 0) begin
                check("R1 hold on", int'(hold), 1);
                check("R3 trial mid", int'(trial), 'h2000);
            end
            if (k == 15) check("R6 sclk enabled", int'(sclk_oe), 1);
            if (poke && k == 4) start = 1'b0;
            if (poke && k == 6) start = 1'b1;
        end
        @(posedge clk); @(negedge clk);
        check("R2 frame closed", int'(frame_n), 1);
        check("R2 hold released", int'(hold), 0);
        check("R3 final trial", int'(trial), x);
        check("R7 R6 enable after frame", int'(sclk_oe), int'(fr));
        check("R9 idle data", int'(sdata), 0);
        start = 1'b0;
        for (int w = 0; w < 4; w++) begin
            @(posedge clk); @(negedge clk);
            if (w == 3) begin
                check("R8 no extra frame", int'(frame_n), 1);
                check("R9 trial held", int'(trial), x);
            end
        end
        @(posedge clk); #1;
        check("R6 R7 idle sclk", int'(sclk), int'(fr));
    endtask

    initial begin
        #900000;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        int corners[9] = '{0, 1, 'h1FFF, 'h2000, 'h2001, 'h3FFE, 'h3FFF, 'h1555, 'h2AAA};
        realtime phases[3] = '{0.2, 2.5, 4.8};
        repeat (3) @(negedge clk);
        check("R9 reset frame", int'(frame_n), 1);
        check("R9 reset hold", int'(hold), 0);
        check("R9 reset data", int'(sdata), 0);
        check("R9 reset trial", int'(trial), 0);
        rst_n = 1'b1;
        n = 0;
        foreach (corners[i]) begin
            run_conv(corners[i], logic'(i % 2), phases[i % 3], 1'b0);
        end
        for (int x = 0; x < 16384; x += 97) begin
            run_conv(x, logic'(n % 2), phases[n % 3], 1'b0);
            n++;
        end
        // R8: start re-armed mid-frame is ignored, in both modes
        run_conv('h0ABC, 1'b0, 2.5, 1'b1);
        run_conv('h3123, 1'b1, 0.2, 1'b1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule